// File: doc/BRIEF.md
# Link State History Ring Recorder

This block keeps a running log of a link-training state machine. Every clock it samples a 6-bit state value, a 3-bit link-rate code and a 3-bit low-power substate code. Whenever the state value differs from the value seen on the previous clock and capture is switched on, it packs the three values into one 32-bit word. That word goes into a ring of 64 entries.

Software drains the log through a status port that always shows the next word a read would return; a read strobe consumes it. Two pointers are kept: one marks the slot last handed to the reader, the other marks the slot last filled by the hardware. When the reader has caught up, the status port keeps showing the word it returned last. Software stops draining when it sees the same word twice in a row. Later transitions append behind the stored read position, so reading carries on with no gap.

A write-masked control register switches capture on and off. The upper half of a control write selects which bits of the lower half take effect.

Top module: `lsr_history_rec`

## Requirements
- R1: After reset both pointers are zero, every ring slot holds zero, the status port reads 0x0000_0000 and the control register reads 0x0000.
- R2: While control bits [2:0] are all 1, each clock whose `link_state` differs from its value on the previous clock appends exactly one entry; a state held steady appends nothing.
- R3: An entry holds the state in bits [5:0], the substate code in bits [10:8] and the rate code in bits [22:20], all sampled on the clock of the change; every other bit is zero.
- R4: When unread entries exist, `stat_data` shows the oldest unread entry and a `stat_rd` strobe consumes it; when none exist, `stat_data` repeats the entry returned by the latest read, and a strobe changes nothing.
- R5: After the reader has caught up, entries appended later are returned in order starting from the first one, with none skipped.
- R6: While control bits [2:0] are not all 1, state changes append nothing, and the pointers and stored entries are kept.
- R7: The ring holds at most 63 unread entries. A change that arrives when 63 are unread and no read is strobed overwrites the oldest unread entry, and the read position moves past it, so the oldest entry still unread is the next one returned.
- R8: A control write updates bit i (0 to 15) only when write-data bit 16+i is 1. Writing 0xFFFF_0007 turns capture on and writing 0xFFFF_0000 turns it off.
- R9: A read strobe and an appended entry in the same clock both take effect: the read returns the entry shown before the clock, and the new entry is queued behind the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control write data: [31:16] per-bit enables, [15:0] values |
| ctrl_rdata | output | 16 | Current control register value |
| stat_rd | input | 1 | Status read strobe; consumes the shown entry |
| stat_data | output | 32 | Entry a read in this clock returns |
| link_state | input | 6 | Link-training state, sampled every clock |
| link_rate | input | 3 | Link-rate code (0 is the slowest generation) |
| link_l1sub | input | 3 | Low-power substate code (1 or 2 when in L1 idle) |

## Verification
The bench builds the block with its default 64-entry ring and 6-bit state. At that depth, long bursts of transitions with no reads fill the ring past its 63-entry limit several times. This brings the overwrite path, pointer wrap-around and reads in the same clock as an overflow within a few hundred cycles. Because the field widths stay at their defaults, every rate and substate code can be driven, and the unused bits can be checked for zero.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
   localparam int unsigned LSR_WORD_W   = 32;
   localparam int unsigned LSR_STATE_W  = 6;
   localparam int unsigned LSR_RATE_W   = 3;
   localparam int unsigned LSR_SUB_W    = 3;
   localparam int unsigned LSR_RATE_LSB = 20;
   localparam int unsigned LSR_SUB_LSB  = 8;
   localparam int unsigned LSR_CTRL_W   = 16;
   localparam int unsigned LSR_EN_BITS  = 3;
endpackage

// File: rtl/lsr_ctrl_reg.sv
module lsr_ctrl_reg #(
   parameter int unsigned CTRL_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [2*CTRL_W-1:0] wdata,
   output logic [CTRL_W-1:0]   q
);
   for (genvar i = 0; i < CTRL_W; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            q[i] <= 1'b0;
         else if (wr && wdata[CTRL_W+i])
            q[i] <= wdata[i];
      end
   end

   // R8: a write whose enable half is all zero leaves the register alone
   a_r8_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata[2*CTRL_W-1:CTRL_W] == '0) |=> $stable(q));
endmodule

// File: rtl/lsr_change_det.sv
module lsr_change_det #(
   parameter int unsigned STATE_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [STATE_W-1:0] state,
   output logic               log_now
);
   logic [STATE_W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= state;
   end

   assign log_now = enable && (state != prev_q);

   // R2: a steady state never produces a log request
   a_r2_steady_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(state) |-> !log_now);
endmodule

// File: rtl/lsr_ring.sv
module lsr_ring #(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data
);
   localparam int unsigned PTR_W = $clog2(DEPTH);

   logic [WORD_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  rd_ptr, last_ptr;
   logic [PTR_W-1:0]  rd_nxt, last_nxt;
   logic              empty, full, rd_adv;

   assign rd_nxt   = rd_ptr + 1'b1;
   assign last_nxt = last_ptr + 1'b1;
   assign empty    = (rd_ptr == last_ptr);
   assign full     = (last_nxt == rd_ptr);
   assign rd_adv   = (rd_en && !empty) || (wr_en && full);
   assign rd_data  = empty ? mem[rd_ptr] : mem[rd_nxt];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr   <= '0;
         last_ptr <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (wr_en) begin
            mem[last_nxt] <= wr_data;
            last_ptr      <= last_nxt;
         end
         if (rd_adv) rd_ptr <= rd_nxt;
      end
   end

   // R2: every accepted write moves the fill pointer by one slot
   a_r2_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> last_ptr == PTR_W'($past(last_ptr) + 1'b1));
   // R6: without a write the fill pointer holds
   a_r6_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(last_ptr));
   // R4: a read with nothing unread leaves the read position unchanged
   a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && empty && !wr_en) |=> $stable(rd_ptr));
   // R7: a write into a full ring pushes the read position forward
   a_r7_overrun_push: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full) |=> rd_ptr == PTR_W'($past(rd_ptr) + 1'b1));
endmodule

// File: rtl/lsr_history_rec.sv
module lsr_history_rec
   import lsr_pkg::*;
#(
   parameter int unsigned DEPTH    = 64,
   parameter int unsigned WORD_W   = LSR_WORD_W,
   parameter int unsigned STATE_W  = LSR_STATE_W,
   parameter int unsigned RATE_W   = LSR_RATE_W,
   parameter int unsigned SUB_W    = LSR_SUB_W,
   parameter int unsigned RATE_LSB = LSR_RATE_LSB,
   parameter int unsigned SUB_LSB  = LSR_SUB_LSB,
   parameter int unsigned CTRL_W   = LSR_CTRL_W,
   parameter int unsigned EN_BITS  = LSR_EN_BITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctrl_wr,
   input  logic [31:0]        ctrl_wdata,
   output logic [15:0]        ctrl_rdata,
   input  logic               stat_rd,
   output logic [31:0]        stat_data,
   input  logic [5:0]         link_state,
   input  logic [2:0]         link_rate,
   input  logic [2:0]         link_l1sub
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (STATE_W > SUB_LSB || SUB_LSB + SUB_W > RATE_LSB || RATE_LSB + RATE_W > WORD_W) begin : g_bad_fields
      $error("entry fields overlap or exceed the word");
   end
   if (WORD_W != 32 || CTRL_W != 16 || STATE_W != 6 || RATE_W != 3 || SUB_W != 3) begin : g_bad_ports
      $error("port widths are fixed by the register layout");
   end
   if (EN_BITS == 0 || EN_BITS > CTRL_W) begin : g_bad_en
      $error("EN_BITS out of range");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic              cap_on;
   logic              log_now;
   logic [WORD_W-1:0] entry;

   lsr_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (ctrl_wr),
      .wdata (ctrl_wdata),
      .q     (ctrl_q)
   );

   assign cap_on     = &ctrl_q[EN_BITS-1:0];
   assign ctrl_rdata = ctrl_q;

   lsr_change_det #(.STATE_W(STATE_W)) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (cap_on),
      .state   (link_state),
      .log_now (log_now)
   );

   always_comb begin
      entry = '0;
      entry[STATE_W-1:0]                = link_state;
      entry[SUB_LSB +: SUB_W]           = link_l1sub;
      entry[RATE_LSB +: RATE_W]         = link_rate;
   end

   lsr_ring #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (log_now),
      .wr_data (entry),
      .rd_en   (stat_rd),
      .rd_data (stat_data)
   );

   // R6: with capture off the ring is never written
   a_r6_off_no_log: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_on |-> !log_now);
   // R3: bits outside the three fields of a shown entry stay zero
   a_r3_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_data & ~32'h0070_073F) == 32'h0);
endmodule

// File: tb/lsr_history_rec_tb.sv
module lsr_history_rec_tb;
   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_wr = 1'b0;
   logic [31:0] ctrl_wdata = '0;
   logic [15:0] ctrl_rdata;
   logic        stat_rd = 1'b0;
   logic [31:0] stat_data;
   logic [5:0]  link_state = '0;
   logic [2:0]  link_rate = '0;
   logic [2:0]  link_l1sub = '0;

   always #5 clk = ~clk;

   lsr_history_rec u_dut (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
      .ctrl_rdata(ctrl_rdata), .stat_rd(stat_rd), .stat_data(stat_data),
      .link_state(link_state), .link_rate(link_rate), .link_l1sub(link_l1sub)
   );

   int          n_chk = 0;
   int          n_bad = 0;
   string       tag = "R1";
   logic [31:0] q[$];
   logic [31:0] m_last = '0;
   logic [5:0]  m_prev = '0;
   logic [15:0] m_ctrl = '0;

   task automatic check32(string r, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h at %0t", r, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] pack(logic [5:0] s, logic [2:0] r, logic [2:0] b);
      return (32'(r) << 20) | (32'(b) << 8) | 32'(s);
   endfunction

   task automatic compare();
      logic [31:0] exp;
      exp = (q.size() > 0) ? q[0] : m_last;
      check32({tag, " stat_data"}, stat_data, exp);
      check32({tag, " ctrl_rdata"}, {16'h0, ctrl_rdata}, {16'h0, m_ctrl});
   endtask

   // one clock: drive at negedge, advance model at the edge, compare at next negedge
   task automatic tick(logic rd, logic wr, logic [31:0] wd,
                       logic [5:0] st, logic [2:0] rt, logic [2:0] sb);
      stat_rd = rd; ctrl_wr = wr; ctrl_wdata = wd;
      link_state = st; link_rate = rt; link_l1sub = sb;
      @(posedge clk);
      if (rd && q.size() > 0) m_last = q.pop_front();
      if ((&m_ctrl[2:0]) && st != m_prev) begin
         q.push_back(pack(st, rt, sb));
         if (q.size() > DEPTH - 1) m_last = q.pop_front();
      end
      m_prev = st;
      if (wr)
         for (int i = 0; i < 16; i++) if (wd[16+i]) m_ctrl[i] = wd[i];
      @(negedge clk);
      compare();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 32'h0, link_state, link_rate, link_l1sub);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      tag = "R1";
      compare();
      idle(2);

      // R8: masked write with no enables changes nothing; no capture results (R6)
      tag = "R8";
      tick(1'b0, 1'b1, 32'h0000_0007, 6'd0, 3'd0, 3'd0);
      tag = "R6";
      tick(1'b0, 1'b0, 32'h0, 6'd5, 3'd1, 3'd0);
      tick(1'b1, 1'b0, 32'h0, 6'd9, 3'd1, 3'd0);
      tag = "R8";
      tick(1'b0, 1'b1, 32'h0001_0001, 6'd9, 3'd0, 3'd0);
      tick(1'b0, 1'b1, 32'hFFFF_0007, 6'd9, 3'd0, 3'd0);

      // R2 / R3: distinct transitions with different rate and substate codes
      tag = "R2";
      tick(1'b0, 1'b0, 32'h0, 6'd17, 3'd2, 3'd0);
      idle(3);
      tag = "R3";
      check32("R3 packed fields", stat_data, 32'h0020_0011);
      tick(1'b0, 1'b0, 32'h0, 6'd20, 3'd4, 3'd2);
      tick(1'b0, 1'b0, 32'h0, 6'd20, 3'd4, 3'd1);
      tick(1'b0, 1'b0, 32'h0, 6'd63, 3'd7, 3'd7);

      // R4: drain, then repeated reads keep showing the last entry
      tag = "R4";
      for (int i = 0; i < 6; i++) tick(1'b1, 1'b0, 32'h0, 6'd63, 3'd7, 3'd7);
      check32("R4 repeat after drain", stat_data, 32'h0070_073F);

      // R5: resume after new transitions
      tag = "R5";
      tick(1'b0, 1'b0, 32'h0, 6'd1, 3'd0, 3'd0);
      tick(1'b0, 1'b0, 32'h0, 6'd2, 3'd1, 3'd0);
      check32("R5 first new entry", stat_data, 32'h0000_0001);
      for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 32'h0, 6'd2, 3'd1, 3'd0);

      // R6: disable, change states, contents kept
      tag = "R6";
      tick(1'b0, 1'b1, 32'hFFFF_0000, 6'd2, 3'd1, 3'd0);
      for (int i = 0; i < 8; i++) tick(1'b0, 1'b0, 32'h0, 6'(i + 30), 3'd0, 3'd0);
      check32("R6 held entry", stat_data, 32'h0010_0002);
      tick(1'b1, 1'b0, 32'h0, 6'd30, 3'd0, 3'd0);
      tick(1'b0, 1'b1, 32'hFFFF_0007, 6'd30, 3'd0, 3'd0);

      // R7: overflow with no reads, then drain
      tag = "R7";
      for (int i = 0; i < 150; i++) tick(1'b0, 1'b0, 32'h0, 6'(i), 3'(i), 3'(i >> 3));
      for (int i = 0; i < 70; i++) tick(1'b1, 1'b0, 32'h0, 6'd21, 3'd0, 3'd0);

      // R9: read and write in the same clock, also while full
      tag = "R9";
      for (int i = 0; i < 80; i++) tick(1'b0, 1'b0, 32'h0, 6'(i + 1), 3'd3, 3'd0);
      for (int i = 0; i < 40; i++) tick(1'b1, 1'b0, 32'h0, 6'(i * 5 + 2), 3'd5, 3'd2);

      // mixed random traffic
      tag = "R2";
      for (int i = 0; i < 4000; i++) begin
         logic [5:0] st;
         logic       wr;
         logic [31:0] wd;
         st = ($urandom % 3 == 0) ? 6'($urandom) : link_state;
         wr = ($urandom % 97 == 0);
         wd = ($urandom % 4 == 0) ? 32'hFFFF_0000 : 32'hFFFF_0007;
         tick($urandom % 3 == 0, wr, wd, st, 3'($urandom), 3'($urandom));
      end

      summary();
      $finish;
   end
endmodule